// File: doc/BRIEF.md
# Smart-Card T=0 Character Transceiver

This block moves single characters over one open-drain smart-card I/O line using the T=0 asynchronous character protocol. Only one direction works at a time: software enables either the transmitter or the receiver. One bit lasts `bit_div` clock cycles. A character is one start bit, eight data bits and one parity bit, followed by a guard period of two bit times. The bit order (LSB or MSB first) and the parity sense (even or odd) can be selected.

The line is never driven high. The block asserts `line_low` to pull the line down, and it reads the line back through a two-stage synchronizer. When the receiver detects bad parity, it drops the character and pulls the line low for one bit time at the start of the guard period. The guard period then follows in full. When the transmitter finishes a character, it releases the line. It then samples the first guard bit to see whether the far end rejected the character, and it stretches its own guard period by one bit time if so. Rejected characters are counted in an 8-bit counter. This counter saturates and is cleared when read.

Top module: `t0_char_xcvr`

## Requirements
- R1: In transmit, a character starts with one bit time of `line_low`=1 (start bit). Eight data bits and one parity bit follow, where a 0 bit pulls the line low and a 1 bit releases it. After a character with no rejection, `busy` falls exactly 12 bit times after the start is accepted.
- R2: When `msb_first`=0, data bit 0 is the first bit sent and received. When `msb_first`=1, data bit 7 is the first.
- R3: When `odd_parity`=0, the parity bit makes the number of ones over data and parity even. When `odd_parity`=1, it makes that number odd.
- R4: The transmitter never drives the line in the guard period. If it reads the line low at mid-bit of the first guard bit, it sets `tx_nack` and keeps `busy` high until 13 bit times after the start. `tx_nack` clears when the next character starts.
- R5: A received character with correct parity is loaded into `rx_data` in the correct bit order, and `rx_valid` pulses for one cycle.
- R6: A received character with bad parity leaves `rx_data` unchanged and gives no `rx_valid`. The receiver then pulls the line low for exactly one bit time after the parity bit. `par_err` is set and stays set until `par_err_clr`.
- R7: `err_cnt` counts receive parity errors. It stops at 255 and does not wrap.
- R8: A cycle with `err_rd`=1 clears `err_cnt` on the next edge. If an error arrives in that same cycle, the counter becomes 1.
- R9: While both `tx_en` and `rx_en` are 1, `mode_err`=1. No character starts in either direction.
- R10: After reset, the line is released, `busy`, `tx_nack`, `par_err` and `rx_valid` are 0, and `err_cnt` is 0.
- R11: A receive start is confirmed at mid-bit. A low pulse shorter than half a bit time is ignored, and the receiver returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| msb_first | input | 1 | 1: MSB first, 0: LSB first |
| odd_parity | input | 1 | 1: odd parity, 0: even parity |
| bit_div | input | DIVW | Clock cycles per bit (at least 4) |
| tx_start | input | 1 | Start sending `tx_data` while idle |
| tx_data | input | 8 | Character to send |
| line_in | input | 1 | Raw level of the I/O line |
| line_low | output | 1 | Open-drain pull-down request |
| busy | output | 1 | A character is in progress |
| tx_nack | output | 1 | Last sent character was rejected |
| rx_data | output | 8 | Receive holding register |
| rx_valid | output | 1 | One-cycle pulse on a new good character |
| par_err | output | 1 | Sticky receive parity-error flag |
| par_err_clr | input | 1 | Clears `par_err` |
| err_cnt | output | 8 | Saturating receive error count |
| err_rd | input | 1 | Read strobe; clears `err_cnt` |
| mode_err | output | 1 | Both directions enabled |

## Verification
Some properties are checked on every cycle:
- the counter stays at 255 and does not wrap;
- a read that meets an error leaves the counter at 1;
- a rejected character is followed by a pull-down and no valid pulse;
- nothing starts while both directions are enabled;
- `tx_nack` rises only after the line was seen low.

Other behaviour can only be shown by the bench scenarios, which model the card side of the wired line:
- the serialized bit values, bit order and parity sense;
- the exact length of the pull-down and of the stretched transmit guard;
- that a bad character leaves the holding register unchanged;
- that a short glitch is ignored.

// File: rtl/t0_char_xcvr.sv
module t0_char_xcvr #(
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_en,
  input  logic            rx_en,
  input  logic            msb_first,
  input  logic            odd_parity,
  input  logic [DIVW-1:0] bit_div,
  input  logic            tx_start,
  input  logic [7:0]      tx_data,
  input  logic            line_in,
  output logic            line_low,
  output logic            busy,
  output logic            tx_nack,
  output logic [7:0]      rx_data,
  output logic            rx_valid,
  output logic            par_err,
  input  logic            par_err_clr,
  output logic [7:0]      err_cnt,
  input  logic            err_rd,
  output logic            mode_err
);

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  logic [1:0]      sync;
  logic            line_q, active, is_tx, par_bit, rx_bad;
  logic [DIVW-1:0] cnt;
  logic [3:0]      bidx;
  logic [7:0]      shreg;

  wire line_s  = sync[1];
  wire fall    = line_q & ~line_s;
  wire tx_ok   = tx_en & ~rx_en;
  wire rx_ok   = rx_en & ~tx_en;
  wire bit_end = (cnt == bit_div - 1'b1);
  wire mid     = (cnt == (bit_div >> 1));
  wire in_data = (bidx >= 4'd1) && (bidx <= 4'd8);
  wire err_inc = active & ~is_tx & bit_end & (bidx == 4'd9)
               & ((^shreg ^ par_bit) != odd_parity);

  assign mode_err = tx_en & rx_en;
  assign busy     = active;
  assign line_low = active & (is_tx
                    ? ((bidx == 4'd0) | (in_data & ~shreg[0]) | ((bidx == 4'd9) & ~par_bit))
                    : (rx_bad & (bidx == 4'd10)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync   <= 2'b11;
      line_q <= 1'b1;
    end else begin
      sync   <= {sync[0], line_in};
      line_q <= line_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      is_tx    <= 1'b0;
      cnt      <= '0;
      bidx     <= '0;
      shreg    <= '0;
      par_bit  <= 1'b0;
      rx_bad   <= 1'b0;
      tx_nack  <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      par_err  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (par_err_clr) par_err <= 1'b0;
      if (!active) begin
        cnt  <= '0;
        bidx <= '0;
        if (tx_ok && tx_start) begin
          active  <= 1'b1;
          is_tx   <= 1'b1;
          shreg   <= msb_first ? rev8(tx_data) : tx_data;
          par_bit <= ^tx_data ^ odd_parity;
          tx_nack <= 1'b0;
        end else if (rx_ok && fall) begin
          active <= 1'b1;
          is_tx  <= 1'b0;
          rx_bad <= 1'b0;
        end
      end else begin
        cnt <= bit_end ? '0 : cnt + 1'b1;
        if (mid) begin
          if (is_tx) begin
            if (bidx == 4'd10 && !line_s) tx_nack <= 1'b1;
          end else if (bidx == 4'd0) begin
            if (line_s) active <= 1'b0;
          end else if (in_data) begin
            shreg <= {line_s, shreg[7:1]};
          end else if (bidx == 4'd9) begin
            par_bit <= line_s;
          end
        end
        if (bit_end) begin
          bidx <= bidx + 1'b1;
          if (is_tx) begin
            if (in_data) shreg <= shreg >> 1;
            if (bidx == (tx_nack ? 4'd12 : 4'd11)) active <= 1'b0;
          end else if (bidx == 4'd9) begin
            if (err_inc) begin
              rx_bad  <= 1'b1;
              par_err <= 1'b1;
            end else begin
              rx_data  <= msb_first ? rev8(shreg) : shreg;
              rx_valid <= 1'b1;
              active   <= 1'b0;
            end
          end else if (bidx == 4'd10) begin
            active <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          err_cnt <= '0;
    else if (err_rd)                     err_cnt <= err_inc ? 8'd1 : 8'd0;
    else if (err_inc && err_cnt != 8'hFF) err_cnt <= err_cnt + 1'b1;
  end

  // R7
  err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == 8'hFF && !err_rd) |=> err_cnt == 8'hFF);
  // R8
  err_rd_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rd && err_inc) |=> err_cnt == 8'd1);
  // R6
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_inc |=> (!rx_valid && line_low && par_err));
  // R9
  mode_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && rx_en && !busy) |=> !busy);
  // R4
  nack_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_nack) |-> $past(!line_s));
  // R5
  rx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !busy);

endmodule

// File: tb/sim_t0_char_xcvr.sv
module sim_t0_char_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;

  logic clk = 0, rst_n = 0;
  logic tx_en = 0, rx_en = 0, msb_first = 0, odd_parity = 0;
  logic tx_start = 0, par_err_clr = 0, err_rd = 0, card_low = 0;
  logic [7:0] tx_data = 0;
  logic line_low, busy, tx_nack, rx_valid, par_err, mode_err, line_w;
  logic [7:0] rx_data, err_cnt;
  int nchk = 0, nfail = 0;
  logic [7:0] last_rx = 0;

  assign line_w = ~(line_low | card_low);
  always #(CLK_PERIOD/2) clk = ~clk;

  t0_char_xcvr #(.DIVW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
    .msb_first(msb_first), .odd_parity(odd_parity), .bit_div(16'(DIV)),
    .tx_start(tx_start), .tx_data(tx_data), .line_in(line_w),
    .line_low(line_low), .busy(busy), .tx_nack(tx_nack), .rx_data(rx_data),
    .rx_valid(rx_valid), .par_err(par_err), .par_err_clr(par_err_clr),
    .err_cnt(err_cnt), .err_rd(err_rd), .mode_err(mode_err));

  // {data, msb_first, odd_parity, corrupt}
  localparam logic [10:0] VEC [0:5] = '{
    {8'hA5, 1'b0, 1'b0, 1'b0}, {8'h3C, 1'b1, 1'b0, 1'b0},
    {8'h01, 1'b0, 1'b1, 1'b0}, {8'h80, 1'b1, 1'b1, 1'b0},
    {8'h5A, 1'b0, 1'b0, 1'b1}, {8'hF0, 1'b1, 1'b1, 1'b1}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic card_send(input logic [7:0] d, input logic msb, input logic odd,
                           input logic bad, output int nd, output logic sawv);
    @(negedge clk);
    tx_en = 0; rx_en = 1; msb_first = msb; odd_parity = odd;
    card_low = 1;
    repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      card_low = ~(msb ? d[7-i] : d[i]);
      repeat (DIV) @(negedge clk);
    end
    card_low = ~(^d ^ odd ^ bad);
    repeat (DIV) @(negedge clk);
    card_low = 0;
    nd = 0; sawv = 0;
    repeat (3*DIV) begin
      @(negedge clk);
      if (line_low) nd++;
      if (rx_valid) sawv = 1;
    end
  endtask

  task automatic rx_vec(input logic [7:0] d, input logic msb, input logic odd, input logic bad);
    int nd; logic v;
    card_send(d, msb, odd, bad, nd, v);
    if (!bad) begin
      chk("R5 rx_data", rx_data, d);
      chk("R5 rx_valid", v, 1);
      chk("R6 no pull on good", nd, 0);
      last_rx = d;
    end else begin
      chk("R6 pull length", nd, DIV);
      chk("R6 no valid", v, 0);
      chk("R6 holding kept", rx_data, last_rx);
      chk("R6 par_err", par_err, 1);
    end
  endtask

  task automatic tx_vec(input logic [7:0] d, input logic msb, input logic odd, input logic bad);
    logic [9:0] got;
    logic [7:0] dd;
    @(negedge clk);
    rx_en = 0; tx_en = 1; msb_first = msb; odd_parity = odd;
    tx_data = d; tx_start = 1;
    @(posedge clk); #1 tx_start = 0;
    for (int i = 0; i < 10; i++) begin
      repeat (i == 0 ? DIV/2 : DIV) @(posedge clk);
      @(negedge clk);
      got[i] = ~line_low;
    end
    for (int i = 0; i < 8; i++) dd[i] = msb ? got[8-i] : got[1+i];
    chk("R1 start bit", got[0], 0);
    chk("R2 data order", dd, d);
    chk("R3 parity", got[9], ^d ^ odd);
    repeat (DIV/2) @(posedge clk);
    if (bad) begin
      #1 card_low = 1;
      repeat (DIV) @(posedge clk);
      #1 card_low = 0;
    end else begin
      @(negedge clk);
      chk("R4 guard released", line_low, 0);
      repeat (DIV) @(posedge clk);
    end
    repeat (bad ? 2*DIV-1 : DIV-1) @(posedge clk);
    @(negedge clk);
    chk("R1 busy before end", busy, 1);
    @(posedge clk); @(negedge clk);
    chk("R4 busy end", busy, 0);
    chk("R4 tx_nack", tx_nack, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int nd; logic v; int bad_n;
    bad_n = 0;
    repeat (3) @(negedge clk);
    // R10
    chk("R10 line_low", line_low, 0);
    chk("R10 busy", busy, 0);
    chk("R10 err_cnt", err_cnt, 0);
    chk("R10 par_err", par_err, 0);
    chk("R10 tx_nack", tx_nack, 0);
    chk("R10 rx_valid", rx_valid, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    foreach (VEC[k]) begin
      rx_vec(VEC[k][10:3], VEC[k][2], VEC[k][1], VEC[k][0]);
      if (VEC[k][0]) bad_n++;
      chk("R7 count", err_cnt, bad_n);
      tx_vec(VEC[k][10:3], VEC[k][2], VEC[k][1], VEC[k][0]);
    end

    // R6 sticky flag clear
    @(negedge clk); par_err_clr = 1;
    @(negedge clk); par_err_clr = 0;
    chk("R6 par_err cleared", par_err, 0);

    // R8 read clears
    @(negedge clk); err_rd = 1;
    @(negedge clk); err_rd = 0;
    chk("R8 cleared", err_cnt, 0);

    // R11 glitch ignored
    @(negedge clk); rx_en = 1; tx_en = 0;
    card_low = 1; repeat (2) @(negedge clk); card_low = 0;
    repeat (2*DIV) @(negedge clk);
    chk("R11 idle after glitch", busy, 0);
    chk("R11 holding kept", rx_data, last_rx);

    // R9 both enabled
    @(negedge clk); tx_en = 1; rx_en = 1;
    @(negedge clk);
    chk("R9 mode_err", mode_err, 1);
    tx_start = 1; @(negedge clk); tx_start = 0;
    card_low = 1; repeat (DIV) @(negedge clk); card_low = 0;
    chk("R9 nothing started", busy, 0);
    chk("R9 line released", line_low, 0);
    tx_en = 0; rx_en = 0;
    @(negedge clk);
    chk("R9 mode_err off", mode_err, 0);

    // R7 saturation
    for (int n = 0; n < 257; n++) card_send(8'h33, 1'b0, 1'b0, 1'b1, nd, v);
    chk("R7 saturated", err_cnt, 255);

    // R8 read and error in the same cycle
    @(negedge clk); par_err_clr = 1;
    @(negedge clk); par_err_clr = 0;
    fork
      card_send(8'h96, 1'b1, 1'b0, 1'b1, nd, v);
      begin
        err_rd = 1;
        while (par_err !== 1'b1) @(negedge clk);
        err_rd = 0;
      end
    join
    chk("R8 read plus error", err_cnt, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule